// File: doc/BRIEF.md
# Receiver Operating-State Sequencer

This block steps a radio receiver through its operating states. After power-on reset, a soft reset or a scheduled self-reset, it waits in an idle phase while the crystal settles. It then optionally copies the configuration parameters and runs a tune/calibration phase. When tuning finishes, it enters receive by itself. From then on, a command port moves it between receive and standby. Any move from standby back to receive first passes through a short synthesizer calibration phase. The state is reported as a 3-bit code, and a set of enables switches the crystal, the digital regulator, the low-frequency oscillator, the synthesizer, the demodulator and the parameter copy.

Every duration is counted in pulses of a slow timebase strobe, `lf_tick_i`. Each duration is a parameter, so the block can be scaled to real time or shrunk for simulation. A self-reset watchdog restarts the whole power-up sequence on a schedule. Its first interval is shorter than the intervals that follow. An input disables the watchdog. A second input keeps the current configuration across warm resets, meaning soft resets and self-resets, but not across power-on reset.

Top module: `rxseq_top`

## Requirements
- R1: `state_code_o` reads 000 in idle, 010 in standby and 100 in receive. The transitional codes are 101 (parameter copy), 001 (tune) and 011 (synthesizer calibration). The codes 110 and 111 never appear.
- R2: After `rst`, the state is idle. It leaves idle on the SETTLE_TICKS-th tick, then spends LOAD_TICKS ticks in copy and TUNE_TICKS ticks in tune, and then reaches receive.
- R3: With `cmd_valid_i` high, command 0010 moves receive to standby on the next clock. Command 1000 moves standby to synthesizer calibration for PLLCAL_TICKS ticks, after which the state is receive.
- R4: Every other command value, any command given with `cmd_valid_i` low, and any command given outside its source state leaves the state unchanged.
- R5: A `soft_rst_i` pulse puts the block in idle on the next clock, from any state, and the full sequence of R2 runs again.
- R6: When idle ends after a warm reset with `cfg_keep_i` high, the copy phase is skipped and the next state is tune. After power-on reset the copy phase always runs.
- R7: A self-reset fires on the FIRST_AR_TICKS-th tick after power-on release. Each later self-reset fires NEXT_AR_TICKS ticks after the previous one. A self-reset acts like a soft reset.
- R8: While `auto_rst_dis_i` is high, no self-reset fires and the interval count is held at zero. A soft reset restarts the interval count from zero.
- R9: The enables {xtal, ldo, lfosc, pll, demod, cfg_load} are:

  | State | Enables |
  |---|---|
  | idle | 111000 |
  | copy | 111001 |
  | tune | 111100 |
  | calibration | 111100 |
  | receive | 111110 |
  | standby | 111000 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| soft_rst_i | input | 1 | Soft reset pulse |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 4 | Mode command code |
| auto_rst_dis_i | input | 1 | Disables the periodic self-reset |
| cfg_keep_i | input | 1 | Keeps the configuration across warm resets |
| lf_tick_i | input | 1 | One-cycle timebase strobe |
| state_code_o | output | 3 | Current state code |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| ldo_en_o | output | 1 | Digital regulator enable |
| lfosc_en_o | output | 1 | Low-frequency oscillator enable |
| pll_en_o | output | 1 | Synthesizer enable |
| demod_en_o | output | 1 | Demodulator enable |
| cfg_load_o | output | 1 | Parameter copy in progress |

## Verification
The bench builds the block with the following parameter values:

| Parameter | Value |
|---|---|
| SETTLE_TICKS | 3 |
| LOAD_TICKS | 2 |
| TUNE_TICKS | 2 |
| PLLCAL_TICKS | 2 |
| FIRST_AR_TICKS | 20 |
| NEXT_AR_TICKS | 30 |

With these values, the first self-reset, the longer follow-on interval, the restart after a soft reset and the re-enable after a disabled period all fall within a few dozen ticks. Each phase boundary can then be checked one tick before and one tick after it. Because the two watchdog intervals differ, a design that reuses the first interval, or that fails to restart the count, lands on a visibly different tick.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'b000,
        ST_TUNE   = 3'b001,
        ST_STBY   = 3'b010,
        ST_PLLCAL = 3'b011,
        ST_RX     = 3'b100,
        ST_LOAD   = 3'b101
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_STBY = 2'd1,
        CMD_RX   = 2'd2
    } cmd_kind_e;

    localparam logic [3:0] OP_STBY = 4'b0010;
    localparam logic [3:0] OP_RX   = 4'b1000;

    typedef struct packed {
        logic xtal;
        logic ldo;
        logic lfosc;
        logic pll;
        logic demod;
        logic load;
    } blk_en_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic cmd_kind_e decode_cmd(input logic vld, input logic [3:0] op);
        if (!vld)          return CMD_NONE;
        if (op == OP_STBY) return CMD_STBY;
        if (op == OP_RX)   return CMD_RX;
        return CMD_NONE;
    endfunction

    function automatic blk_en_t enables_of(input seq_state_e s);
        blk_en_t e;
        e = '{xtal: 1'b1, ldo: 1'b1, lfosc: 1'b1, pll: 1'b0, demod: 1'b0, load: 1'b0};
        case (s)
            ST_LOAD:   e.load  = 1'b1;
            ST_TUNE:   e.pll   = 1'b1;
            ST_PLLCAL: e.pll   = 1'b1;
            ST_RX: begin
                e.pll   = 1'b1;
                e.demod = 1'b1;
            end
            default: ;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/rxseq_span_cnt.sv
module rxseq_span_cnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_q <= '0;
        else if (tick_i && (cnt_q != {W{1'b1}}))
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R2: a clear request always lands at zero
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/rxseq_autorst.sv
module rxseq_autorst #(
    parameter int unsigned FIRST_AR_TICKS = 128000,
    parameter int unsigned NEXT_AR_TICKS  = 537600
) (
    input  logic clk,
    input  logic rst,
    input  logic lf_tick_i,
    input  logic dis_i,
    input  logic soft_i,
    output logic fire_o
);
    import rxseq_pkg::*;

    localparam int unsigned AW = $clog2(max2(FIRST_AR_TICKS, NEXT_AR_TICKS) + 1);
    localparam logic [AW-1:0] LAST_FIRST = AW'(FIRST_AR_TICKS - 1);
    localparam logic [AW-1:0] LAST_NEXT  = AW'(NEXT_AR_TICKS - 1);

    logic [AW-1:0] cnt;
    logic          first_done_q;
    logic [AW-1:0] last;
    logic          fire;

    assign last = first_done_q ? LAST_NEXT : LAST_FIRST;
    assign fire = lf_tick_i && !dis_i && (cnt == last);

    rxseq_span_cnt #(.W(AW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr_i (dis_i || soft_i || fire),
        .tick_i(lf_tick_i),
        .cnt_o (cnt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            first_done_q <= 1'b0;
        else if (fire)
            first_done_q <= 1'b1;
    end

    assign fire_o = fire;

    // R7: each firing restarts the interval
    a_r7_fire_restarts: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> (cnt == '0));

    // R8: a disabled watchdog keeps its count at zero
    a_r8_off_holds_zero: assert property (@(posedge clk) disable iff (rst)
        dis_i |=> (cnt == '0));

    // R8: a soft reset restarts the count
    a_r8_soft_restarts: assert property (@(posedge clk) disable iff (rst)
        soft_i |=> (cnt == '0));

endmodule

// File: rtl/rxseq_fsm.sv
module rxseq_fsm #(
    parameter int unsigned SETTLE_TICKS = 80,
    parameter int unsigned LOAD_TICKS   = 8,
    parameter int unsigned TUNE_TICKS   = 24,
    parameter int unsigned PLLCAL_TICKS = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   soft_i,
    input  logic                   ar_fire_i,
    input  logic                   cmd_valid_i,
    input  logic [3:0]             cmd_i,
    input  logic                   cfg_keep_i,
    input  logic                   lf_tick_i,
    output rxseq_pkg::seq_state_e  state_o
);
    import rxseq_pkg::*;

    localparam int unsigned DMAX = max2(max2(SETTLE_TICKS, LOAD_TICKS),
                                        max2(TUNE_TICKS, PLLCAL_TICKS));
    localparam int unsigned DW = $clog2(DMAX + 1);
    localparam logic [DW-1:0] END_SETTLE = DW'(SETTLE_TICKS - 1);
    localparam logic [DW-1:0] END_LOAD   = DW'(LOAD_TICKS - 1);
    localparam logic [DW-1:0] END_TUNE   = DW'(TUNE_TICKS - 1);
    localparam logic [DW-1:0] END_PLLCAL = DW'(PLLCAL_TICKS - 1);

    seq_state_e    state_q, state_d;
    logic          warm_q;
    logic [DW-1:0] dwell;
    logic [DW-1:0] dwell_end;
    logic          dwell_done;
    logic          restart;
    cmd_kind_e     cmd_kind;

    assign restart  = soft_i || ar_fire_i;
    assign cmd_kind = decode_cmd(cmd_valid_i, cmd_i);

    always_comb begin
        case (state_q)
            ST_IDLE:   dwell_end = END_SETTLE;
            ST_LOAD:   dwell_end = END_LOAD;
            ST_TUNE:   dwell_end = END_TUNE;
            ST_PLLCAL: dwell_end = END_PLLCAL;
            default:   dwell_end = '0;
        endcase
    end

    assign dwell_done = lf_tick_i && (dwell == dwell_end);

    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:
                    if (dwell_done)
                        state_d = (warm_q && cfg_keep_i) ? ST_TUNE : ST_LOAD;
                ST_LOAD:
                    if (dwell_done) state_d = ST_TUNE;
                ST_TUNE:
                    if (dwell_done) state_d = ST_RX;
                ST_PLLCAL:
                    if (dwell_done) state_d = ST_RX;
                ST_RX:
                    if (cmd_kind == CMD_STBY) state_d = ST_STBY;
                ST_STBY:
                    if (cmd_kind == CMD_RX) state_d = ST_PLLCAL;
                default:
                    state_d = ST_IDLE;
            endcase
        end
    end

    rxseq_span_cnt #(.W(DW)) u_dwell (
        .clk   (clk),
        .rst   (rst),
        .clr_i (restart || (state_d != state_q)),
        .tick_i(lf_tick_i),
        .cnt_o (dwell)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            warm_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (restart)
                warm_q <= 1'b1;
        end
    end

    assign state_o = state_q;

    // R5: soft reset reaches idle on the next clock
    a_r5_soft_to_idle: assert property (@(posedge clk) disable iff (rst)
        soft_i |=> (state_q == ST_IDLE));

    // R4: receive holds unless a standby command or a reset arrives
    a_r4_rx_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RX && !(cmd_valid_i && cmd_i == OP_STBY) && !restart)
        |=> (state_q == ST_RX));

    // R3: receive is entered only after tune or synthesizer calibration
    a_r3_rx_via_cal: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RX && $past(state_q) != ST_RX)
        |-> ($past(state_q) == ST_TUNE || $past(state_q) == ST_PLLCAL));

    // R6: idle goes straight to tune only on a warm reset with keep set
    a_r6_skip_needs_warm: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TUNE && $past(state_q) == ST_IDLE)
        |-> $past(warm_q && cfg_keep_i));

    // R1: standby is reached only from receive
    a_r1_stby_from_rx: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STBY && $past(state_q) != ST_STBY)
        |-> ($past(state_q) == ST_RX));

endmodule

// File: rtl/rxseq_top.sv
module rxseq_top #(
    parameter int unsigned SETTLE_TICKS   = 80,
    parameter int unsigned LOAD_TICKS     = 8,
    parameter int unsigned TUNE_TICKS     = 24,
    parameter int unsigned PLLCAL_TICKS   = 8,
    parameter int unsigned FIRST_AR_TICKS = 128000,
    parameter int unsigned NEXT_AR_TICKS  = 537600
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       soft_rst_i,
    input  logic       cmd_valid_i,
    input  logic [3:0] cmd_i,
    input  logic       auto_rst_dis_i,
    input  logic       cfg_keep_i,
    input  logic       lf_tick_i,
    output logic [2:0] state_code_o,
    output logic       xtal_en_o,
    output logic       ldo_en_o,
    output logic       lfosc_en_o,
    output logic       pll_en_o,
    output logic       demod_en_o,
    output logic       cfg_load_o
);
    import rxseq_pkg::*;

    logic       ar_fire;
    seq_state_e state;
    blk_en_t    en;

    rxseq_autorst #(
        .FIRST_AR_TICKS(FIRST_AR_TICKS),
        .NEXT_AR_TICKS (NEXT_AR_TICKS)
    ) u_autorst (
        .clk      (clk),
        .rst      (rst),
        .lf_tick_i(lf_tick_i),
        .dis_i    (auto_rst_dis_i),
        .soft_i   (soft_rst_i),
        .fire_o   (ar_fire)
    );

    rxseq_fsm #(
        .SETTLE_TICKS(SETTLE_TICKS),
        .LOAD_TICKS  (LOAD_TICKS),
        .TUNE_TICKS  (TUNE_TICKS),
        .PLLCAL_TICKS(PLLCAL_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .soft_i     (soft_rst_i),
        .ar_fire_i  (ar_fire),
        .cmd_valid_i(cmd_valid_i),
        .cmd_i      (cmd_i),
        .cfg_keep_i (cfg_keep_i),
        .lf_tick_i  (lf_tick_i),
        .state_o    (state)
    );

    assign en           = enables_of(state);
    assign state_code_o = state;
    assign xtal_en_o    = en.xtal;
    assign ldo_en_o     = en.ldo;
    assign lfosc_en_o   = en.lfosc;
    assign pll_en_o     = en.pll;
    assign demod_en_o   = en.demod;
    assign cfg_load_o   = en.load;

    // R9: the demodulator runs only while receive is reported
    a_r9_demod_only_rx: assert property (@(posedge clk) disable iff (rst)
        demod_en_o |-> (state_code_o == 3'b100));

    // R1: unused codes never show
    a_r1_code_legal: assert property (@(posedge clk) disable iff (rst)
        state_code_o[2:1] != 2'b11);

endmodule

// File: tb/rxseq_top_tb.sv
module rxseq_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst_i = 1'b0;
    logic       cmd_valid_i = 1'b0;
    logic [3:0] cmd_i = 4'b0000;
    logic       auto_rst_dis_i = 1'b1;
    logic       cfg_keep_i = 1'b0;
    logic       lf_tick_i = 1'b0;
    logic [2:0] state_code_o;
    logic       xtal_en_o, ldo_en_o, lfosc_en_o, pll_en_o, demod_en_o, cfg_load_o;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [2:0] C_IDLE = 3'b000, C_TUNE = 3'b001, C_STBY = 3'b010,
                           C_CAL  = 3'b011, C_RX   = 3'b100, C_LOAD = 3'b101;

    always #2.5 clk = ~clk;

    rxseq_top #(
        .SETTLE_TICKS(3), .LOAD_TICKS(2), .TUNE_TICKS(2), .PLLCAL_TICKS(2),
        .FIRST_AR_TICKS(20), .NEXT_AR_TICKS(30)
    ) u_dut (
        .clk(clk), .rst(rst), .soft_rst_i(soft_rst_i), .cmd_valid_i(cmd_valid_i),
        .cmd_i(cmd_i), .auto_rst_dis_i(auto_rst_dis_i), .cfg_keep_i(cfg_keep_i),
        .lf_tick_i(lf_tick_i), .state_code_o(state_code_o), .xtal_en_o(xtal_en_o),
        .ldo_en_o(ldo_en_o), .lfosc_en_o(lfosc_en_o), .pll_en_o(pll_en_o),
        .demod_en_o(demod_en_o), .cfg_load_o(cfg_load_o)
    );

    function automatic logic [5:0] exp_en(input logic [2:0] c);
        case (c)
            C_LOAD:  return 6'b111001;
            C_TUNE:  return 6'b111100;
            C_CAL:   return 6'b111100;
            C_RX:    return 6'b111110;
            default: return 6'b111000;
        endcase
    endfunction

    task automatic chk_state(input string tag, input logic [2:0] exp);
        n_chk++;
        if (state_code_o !== exp) begin
            n_bad++;
            $display("FAIL %s: state actual %b expected %b", tag, state_code_o, exp);
        end
    endtask

    task automatic chk_en(input string tag, input logic [2:0] code);
        logic [5:0] got;
        got = {xtal_en_o, ldo_en_o, lfosc_en_o, pll_en_o, demod_en_o, cfg_load_o};
        n_chk++;
        if (got !== exp_en(code)) begin
            n_bad++;
            $display("FAIL %s: enables actual %b expected %b", tag, got, exp_en(code));
        end
    endtask

    task automatic do_por(input logic keep, input logic dis);
        @(negedge clk);
        rst = 1'b1; cfg_keep_i = keep; auto_rst_dis_i = dis;
        soft_rst_i = 1'b0; cmd_valid_i = 1'b0; lf_tick_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); lf_tick_i = 1'b1;
            @(negedge clk); lf_tick_i = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic send_cmd(input logic vld, input logic [3:0] op);
        @(negedge clk); cmd_valid_i = vld; cmd_i = op;
        @(negedge clk); cmd_valid_i = 1'b0; cmd_i = 4'b0000;
    endtask

    task automatic soft_pulse();
        @(negedge clk); soft_rst_i = 1'b1;
        @(negedge clk); soft_rst_i = 1'b0;
    endtask

    task automatic t_power_on();
        do_por(1'b0, 1'b1);
        chk_state("R2 reset idle", C_IDLE);
        chk_en("R9 idle", C_IDLE);
        ticks(2); chk_state("R2 settle not done", C_IDLE);
        ticks(1); chk_state("R2 copy phase", C_LOAD);
        chk_en("R9 copy", C_LOAD);
        ticks(1); chk_state("R2 copy held", C_LOAD);
        ticks(1); chk_state("R2 tune phase", C_TUNE);
        chk_en("R9 tune", C_TUNE);
        ticks(1); chk_state("R2 tune held", C_TUNE);
        ticks(1); chk_state("R1 R2 receive", C_RX);
        chk_en("R9 receive", C_RX);
    endtask

    task automatic t_commands();
        do_por(1'b0, 1'b1);
        ticks(7); chk_state("R3 in receive", C_RX);
        send_cmd(1'b1, 4'b0010); chk_state("R3 to standby", C_STBY);
        chk_en("R9 standby", C_STBY);
        send_cmd(1'b1, 4'b1000); chk_state("R3 calibration", C_CAL);
        chk_en("R9 calibration", C_CAL);
        ticks(1); chk_state("R3 calibration held", C_CAL);
        ticks(1); chk_state("R3 back to receive", C_RX);
    endtask

    task automatic t_ignored();
        do_por(1'b0, 1'b1);
        send_cmd(1'b1, 4'b1000); chk_state("R4 rx cmd in idle", C_IDLE);
        send_cmd(1'b1, 4'b0010); chk_state("R4 stby cmd in idle", C_IDLE);
        ticks(3); chk_state("R4 idle timing intact", C_LOAD);
        ticks(4); chk_state("R4 receive", C_RX);
        send_cmd(1'b1, 4'b1000); chk_state("R4 rx cmd in rx", C_RX);
        send_cmd(1'b1, 4'b0000); chk_state("R4 code 0000", C_RX);
        send_cmd(1'b1, 4'b1111); chk_state("R4 code 1111", C_RX);
        send_cmd(1'b1, 4'b0011); chk_state("R4 code 0011", C_RX);
        send_cmd(1'b1, 4'b1010); chk_state("R4 code 1010", C_RX);
        send_cmd(1'b0, 4'b0010); chk_state("R4 strobe low", C_RX);
        send_cmd(1'b1, 4'b0010); chk_state("R4 standby", C_STBY);
        send_cmd(1'b1, 4'b0010); chk_state("R4 stby cmd in stby", C_STBY);
        send_cmd(1'b1, 4'b0100); chk_state("R4 code 0100 in stby", C_STBY);
        send_cmd(1'b1, 4'b1000); chk_state("R4 to calibration", C_CAL);
        send_cmd(1'b1, 4'b0010); chk_state("R4 stby cmd in cal", C_CAL);
    endtask

    task automatic t_soft_and_keep();
        do_por(1'b0, 1'b1);
        ticks(7);
        send_cmd(1'b1, 4'b0010);
        send_cmd(1'b1, 4'b1000);
        soft_pulse(); chk_state("R5 soft from calibration", C_IDLE);
        chk_en("R5 R9 idle after soft", C_IDLE);
        ticks(3); chk_state("R5 R6 reload without keep", C_LOAD);
        ticks(4); chk_state("R5 receive again", C_RX);
        do_por(1'b1, 1'b1);
        ticks(3); chk_state("R6 power-on always copies", C_LOAD);
        ticks(4);
        soft_pulse(); chk_state("R5 soft from receive", C_IDLE);
        ticks(3); chk_state("R6 keep skips copy", C_TUNE);
        ticks(2); chk_state("R6 receive after skip", C_RX);
    endtask

    task automatic t_autoreset();
        do_por(1'b1, 1'b0);
        ticks(19); chk_state("R7 before first self-reset", C_RX);
        ticks(1);  chk_state("R7 first self-reset", C_IDLE);
        ticks(3);  chk_state("R6 R7 warm keep skips copy", C_TUNE);
        ticks(26); chk_state("R7 before later self-reset", C_RX);
        ticks(1);  chk_state("R7 later self-reset", C_IDLE);
    endtask

    task automatic t_autodis();
        do_por(1'b0, 1'b1);
        ticks(40); chk_state("R8 disabled no reset", C_RX);
        @(negedge clk); auto_rst_dis_i = 1'b0;
        ticks(19); chk_state("R8 count from zero after enable", C_RX);
        ticks(1);  chk_state("R8 fires after enable", C_IDLE);
        do_por(1'b0, 1'b0);
        ticks(15);
        soft_pulse(); chk_state("R8 soft reset", C_IDLE);
        ticks(19); chk_state("R8 soft restarts count", C_RX);
        ticks(1);  chk_state("R8 fires after restart", C_IDLE);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_power_on();
        t_commands();
        t_ignored();
        t_soft_and_keep();
        t_autoreset();
        t_autodis();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule